// File: doc/BRIEF.md
# Lock-on-Fill Replacement Controller

This controller keeps the lock state and picks victims for a set-associative cache whose accesses must not reveal a repeating address pattern. Memory may be asked for each block at most once between two permutations of the address map. It does this by locking every block when its fill arrives and by never offering a locked block for eviction. Hits leave the lock state alone. The controller holds no tags and no data. The requester presents a lookup with its hit or miss result. On a miss it receives a victim way, or a stall if no way in the set can be evicted. It reports each completed fill back to the controller.

The controller keeps a running count of locked blocks. When half of all blocks are locked, it raises a permutation request early, so the permutation engine can start before the cache fills up. When every block is locked, the full flag rises, and from then on every miss stalls. A one-cycle done pulse from the permutation engine clears every lock in a single cycle. The same pulse drops the request and the full flag, and a new epoch begins.

Top module: `lockfill_ctrl`

## Requirements
- R1: After synchronous reset no block is locked, and vic_valid, miss_stall, perm_req and all_locked are all 0.
- R2: A lookup with lk_hit=1 changes no lock state and produces neither vic_valid nor miss_stall in the next cycle.
- R3: A lookup with lk_hit=0 on set S produces, one cycle later, vic_valid=1, vic_set=S and vic_way equal to the lowest-numbered unlocked way of S, judged on the lock state before that edge.
- R4: A fill_valid pulse for (set, way) locks that way, and no later miss returns it as a victim until the next perm_done.
- R5: A fill of a way that is already locked changes neither the lock state nor the locked-block count.
- R6: A miss on a set whose ways are all locked produces miss_stall=1 and vic_valid=0 one cycle later.
- R7: perm_req rises on the clock edge that registers the lock that brings the locked-block count to NUM_SETS*NUM_WAYS/2. It stays at 1 until perm_done.
- R8: all_locked rises on the edge that registers the lock of the last unlocked block. While it is set, every miss stalls.
- R9: A perm_done pulse clears every lock in that one edge and clears perm_req, all_locked and the count. A fill presented in the same cycle as perm_done is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup strobe |
| lk_hit | input | 1 | Lookup result: 1 hit, 0 miss |
| lk_set | input | SET_W | Set index of the lookup |
| fill_valid | input | 1 | Fill completed strobe |
| fill_set | input | SET_W | Set index of the fill |
| fill_way | input | WAY_W | Way written by the fill |
| perm_done | input | 1 | Permutation finished pulse |
| vic_valid | output | 1 | Registered: victim offered for the previous miss |
| vic_set | output | SET_W | Registered: set of the last miss |
| vic_way | output | WAY_W | Registered: chosen victim way |
| miss_stall | output | 1 | Registered: previous miss found no unlocked way |
| perm_req | output | 1 | Permutation request, held until perm_done |
| all_locked | output | 1 | Every block is locked |

## Verification
The bench builds the controller with 4 sets of 4 ways. This puts the half threshold at 8 locks and full at 16, so a directed sequence can cross both thresholds and reach the global unlock within a few hundred cycles. It can still fill one set completely while the others stay open. The small geometry exercises the per-set stall separately from the global stall. It fills ways out of order to check lowest-index selection, and it repeats a fill so that a wrongly counted duplicate would move the request by one lock. It also pairs perm_done with a fill to check that the clear takes priority.

// File: rtl/lockfill_pkg.sv
package lockfill_pkg;
  // Index width that never collapses to zero bits.
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/lf_lock_array.sv
module lf_lock_array
  import lockfill_pkg::*;
#(
  parameter int NUM_SETS = 64,
  parameter int NUM_WAYS = 8,
  localparam int SET_W = idx_w(NUM_SETS),
  localparam int WAY_W = idx_w(NUM_WAYS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr_all,
  input  logic                set_en,
  input  logic [SET_W-1:0]    set_idx,
  input  logic [WAY_W-1:0]    set_way,
  input  logic [SET_W-1:0]    rd_set,
  output logic [NUM_WAYS-1:0] rd_row,
  output logic                set_was_locked
);
  logic [NUM_WAYS-1:0] lock_q [NUM_SETS];

  // One row of flops per set; the global clear must reach every bit in one
  // cycle, so the lock state cannot live in a block RAM.
  for (genvar s = 0; s < NUM_SETS; s++) begin : g_row
    always_ff @(posedge clk) begin
      if (rst || clr_all) begin
        lock_q[s] <= '0;
      end else if (set_en && (set_idx == SET_W'(s))) begin
        lock_q[s][set_way] <= 1'b1;
      end
    end
  end

  assign rd_row         = lock_q[rd_set];
  assign set_was_locked = lock_q[set_idx][set_way];
endmodule

// File: rtl/lf_victim_pick.sv
module lf_victim_pick
  import lockfill_pkg::*;
#(
  parameter int NUM_WAYS = 8,
  localparam int WAY_W = idx_w(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0] locked_row,
  output logic                found,
  output logic [WAY_W-1:0]    way
);
  // Lowest-index unlocked way wins.
  always_comb begin
    found = 1'b0;
    way   = '0;
    for (int i = NUM_WAYS - 1; i >= 0; i--) begin
      if (!locked_row[i]) begin
        found = 1'b1;
        way   = WAY_W'(i);
      end
    end
  end
endmodule

// File: rtl/lf_lock_counter.sv
module lf_lock_counter #(
  parameter int TOTAL = 512,
  localparam int HALF  = TOTAL / 2,
  localparam int CNT_W = $clog2(TOTAL + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic clr,
  output logic half_req,
  output logic full
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             req_q, full_q;

  always_comb begin
    if (clr)                                  cnt_d = '0;
    else if (inc && (cnt_q != CNT_W'(TOTAL))) cnt_d = cnt_q + CNT_W'(1);
    else                                      cnt_d = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      req_q  <= 1'b0;
      full_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      req_q  <= clr ? 1'b0 : (req_q | (cnt_d >= CNT_W'(HALF)));
      full_q <= clr ? 1'b0 : (cnt_d == CNT_W'(TOTAL));
    end
  end

  assign half_req = req_q;
  assign full     = full_q;
endmodule

// File: rtl/lockfill_ctrl.sv
module lockfill_ctrl
  import lockfill_pkg::*;
#(
  parameter int NUM_SETS = 64,
  parameter int NUM_WAYS = 8,
  localparam int SET_W = idx_w(NUM_SETS),
  localparam int WAY_W = idx_w(NUM_WAYS),
  localparam int TOTAL = NUM_SETS * NUM_WAYS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic             lk_hit,
  input  logic [SET_W-1:0] lk_set,
  input  logic             fill_valid,
  input  logic [SET_W-1:0] fill_set,
  input  logic [WAY_W-1:0] fill_way,
  input  logic             perm_done,
  output logic             vic_valid,
  output logic [SET_W-1:0] vic_set,
  output logic [WAY_W-1:0] vic_way,
  output logic             miss_stall,
  output logic             perm_req,
  output logic             all_locked
);
  logic [NUM_WAYS-1:0] lk_row;
  logic                fill_dup;
  logic                pick_found;
  logic [WAY_W-1:0]    pick_way;
  logic                miss;
  logic                new_lock;

  lf_lock_array #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_locks (
    .clk            (clk),
    .rst            (rst),
    .clr_all        (perm_done),
    .set_en         (fill_valid),
    .set_idx        (fill_set),
    .set_way        (fill_way),
    .rd_set         (lk_set),
    .rd_row         (lk_row),
    .set_was_locked (fill_dup)
  );

  lf_victim_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
    .locked_row (lk_row),
    .found      (pick_found),
    .way        (pick_way)
  );

  assign new_lock = fill_valid && !fill_dup && !perm_done;

  lf_lock_counter #(.TOTAL(TOTAL)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .inc      (new_lock),
    .clr      (perm_done),
    .half_req (perm_req),
    .full     (all_locked)
  );

  assign miss = lk_valid && !lk_hit;

  logic             vic_valid_q, miss_stall_q;
  logic [SET_W-1:0] vic_set_q;
  logic [WAY_W-1:0] vic_way_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vic_valid_q  <= 1'b0;
      miss_stall_q <= 1'b0;
      vic_set_q    <= '0;
      vic_way_q    <= '0;
    end else begin
      vic_valid_q  <= miss && pick_found;
      miss_stall_q <= miss && !pick_found;
      if (miss)               vic_set_q <= lk_set;
      if (miss && pick_found) vic_way_q <= pick_way;
    end
  end

  assign vic_valid  = vic_valid_q;
  assign miss_stall = miss_stall_q;
  assign vic_set    = vic_set_q;
  assign vic_way    = vic_way_q;
endmodule

// File: rtl/lockfill_ctrl_chk.sv
module lockfill_ctrl_chk
  import lockfill_pkg::*;
#(
  parameter int NUM_SETS = 64,
  parameter int NUM_WAYS = 8,
  localparam int SET_W = idx_w(NUM_SETS),
  localparam int WAY_W = idx_w(NUM_WAYS)
) (
  input logic             clk,
  input logic             rst,
  input logic             lk_valid,
  input logic             lk_hit,
  input logic [SET_W-1:0] lk_set,
  input logic             fill_valid,
  input logic [SET_W-1:0] fill_set,
  input logic [WAY_W-1:0] fill_way,
  input logic             perm_done,
  input logic             vic_valid,
  input logic [SET_W-1:0] vic_set,
  input logic [WAY_W-1:0] vic_way,
  input logic             miss_stall,
  input logic             perm_req,
  input logic             all_locked
);
  // Shadow lock state built only from the port traffic.
  logic [NUM_WAYS-1:0] shadow_q [NUM_SETS];
  logic [NUM_WAYS-1:0] seen_row_q;
  logic [SET_W-1:0]    seen_set_q;
  logic [NUM_WAYS-1:0] below_mask;

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_sh
    always_ff @(posedge clk) begin
      if (rst || perm_done)                          shadow_q[s] <= '0;
      else if (fill_valid && fill_set == SET_W'(s))  shadow_q[s][fill_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_row_q <= '0;
      seen_set_q <= '0;
    end else begin
      seen_row_q <= shadow_q[lk_set];
      seen_set_q <= lk_set;
    end
  end

  assign below_mask = (NUM_WAYS'(1) << vic_way) - NUM_WAYS'(1);

  // R2
  hit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_hit) |=> (!vic_valid && !miss_stall));

  // R3
  miss_answered_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !lk_hit) |=> (vic_valid != miss_stall));

  // R3
  victim_lowest_chk: assert property (@(posedge clk) disable iff (rst)
    vic_valid |-> (((seen_row_q & below_mask) == below_mask) && vic_set == seen_set_q));

  // R4
  victim_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
    vic_valid |-> !seen_row_q[vic_way]);

  // R6
  stall_only_full_chk: assert property (@(posedge clk) disable iff (rst)
    miss_stall |-> (&seen_row_q));

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (perm_req && !perm_done) |=> perm_req);

  // R8
  full_implies_req_chk: assert property (@(posedge clk) disable iff (rst)
    all_locked |-> perm_req);

  // R9
  done_clears_chk: assert property (@(posedge clk) disable iff (rst)
    perm_done |=> (!perm_req && !all_locked));
endmodule

bind lockfill_ctrl lockfill_ctrl_chk #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_chk (.*);

// File: tb/lockfill_ctrl_bench.sv
module lockfill_ctrl_bench;
  localparam int SETS = 4;
  localparam int WAYS = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lk_valid = 1'b0, lk_hit = 1'b0;
  logic [1:0] lk_set = '0;
  logic       fill_valid = 1'b0;
  logic [1:0] fill_set = '0, fill_way = '0;
  logic       perm_done = 1'b0;
  logic       vic_valid, miss_stall, perm_req, all_locked;
  logic [1:0] vic_set, vic_way;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  lockfill_ctrl #(.NUM_SETS(SETS), .NUM_WAYS(WAYS)) u_lockfill_ctrl (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_hit(lk_hit), .lk_set(lk_set),
    .fill_valid(fill_valid), .fill_set(fill_set), .fill_way(fill_way),
    .perm_done(perm_done), .vic_valid(vic_valid), .vic_set(vic_set),
    .vic_way(vic_way), .miss_stall(miss_stall), .perm_req(perm_req),
    .all_locked(all_locked)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic lookup(input bit hit, input int set);
    @(negedge clk);
    lk_valid = 1'b1; lk_hit = hit; lk_set = 2'(set);
    @(posedge clk); #1;
    @(negedge clk);
    lk_valid = 1'b0; lk_hit = 1'b0;
  endtask

  task automatic expect_victim(input string tag, input int set, input int way);
    lookup(1'b0, set);
    check({tag, " vic_valid"}, int'(vic_valid), 1);
    check({tag, " vic_set"}, int'(vic_set), set);
    check({tag, " vic_way"}, int'(vic_way), way);
    check({tag, " no stall"}, int'(miss_stall), 0);
  endtask

  task automatic expect_stall(input string tag, input int set);
    lookup(1'b0, set);
    check({tag, " stall"}, int'(miss_stall), 1);
    check({tag, " no victim"}, int'(vic_valid), 0);
  endtask

  task automatic fill(input int set, input int way);
    @(negedge clk);
    fill_valid = 1'b1; fill_set = 2'(set); fill_way = 2'(way);
    @(posedge clk); #1;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 vic_valid", int'(vic_valid), 0);
    check("R1 miss_stall", int'(miss_stall), 0);
    check("R1 perm_req", int'(perm_req), 0);
    check("R1 all_locked", int'(all_locked), 0);
  endtask

  task automatic t_hit();
    fill(0, 0);
    lookup(1'b1, 0);
    check("R2 hit no victim", int'(vic_valid), 0);
    check("R2 hit no stall", int'(miss_stall), 0);
    expect_victim("R2 lock unchanged", 0, 1);
  endtask

  task automatic t_pick();
    expect_victim("R3 empty set", 1, 0);
    fill(1, 0);
    expect_victim("R4 way0 locked", 1, 1);
    fill(1, 2);
    expect_victim("R3 out of order", 1, 1);
    fill(1, 2);
    fill(1, 1);
    expect_victim("R5 dup keeps lock", 1, 3);
    fill(1, 3);
    expect_stall("R6 set full", 1);
    expect_victim("R6 other set open", 2, 0);
  endtask

  task automatic t_half();
    // locks so far: set0 w0, set1 all = 5; the duplicate must not count
    fill(0, 1);
    fill(0, 2);
    check("R7 low at 7 (R5 dup)", int'(perm_req), 0);
    fill(0, 3);
    check("R7 high at 8", int'(perm_req), 1);
    check("R8 not full at 8", int'(all_locked), 0);
    repeat (5) @(posedge clk);
    #1 check("R7 held", int'(perm_req), 1);
  endtask

  task automatic t_full();
    for (int w = 0; w < WAYS; w++) fill(2, w);
    for (int w = 0; w < WAYS - 1; w++) fill(3, w);
    check("R8 not full at 15", int'(all_locked), 0);
    fill(3, 3);
    check("R8 full at 16", int'(all_locked), 1);
    expect_stall("R8 global stall", 0);
  endtask

  task automatic t_done();
    @(negedge clk);
    perm_done = 1'b1; fill_valid = 1'b1; fill_set = 2'd2; fill_way = 2'd0;
    @(posedge clk); #1;
    check("R9 req cleared", int'(perm_req), 0);
    check("R9 full cleared", int'(all_locked), 0);
    @(negedge clk);
    perm_done = 1'b0; fill_valid = 1'b0;
    expect_victim("R9 fill discarded", 2, 0);
    expect_victim("R9 set3 unlocked", 3, 0);
    for (int w = 0; w < WAYS; w++) fill(0, w);
    for (int w = 0; w < WAYS - 1; w++) fill(1, w);
    check("R9 count restarted low", int'(perm_req), 0);
    fill(1, 3);
    check("R9 count restarted high", int'(perm_req), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1;
    t_reset();
    t_hit();
    t_pick();
    t_half();
    t_full();
    t_done();
    finish_run();
  end

  initial begin
    #(20 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule